// File: doc/BRIEF.md
# Handshaked Buffered Byte Output Port

This block delivers bytes written by a host to an external peripheral over an interlocked two-wire handshake. When the host writes a byte, the byte goes into a small output queue. Whenever the port is idle and the queue holds a byte, the port drives the oldest byte onto the data pins. One clock later it raises a data-ready line. The peripheral answers with a rising edge on its acknowledge line, which means "latched, ready for more". The port then drops data-ready, removes the byte from the queue and, if another byte is waiting, presents that one.

A configuration input chooses how many bytes the queue may hold. With shallow buffering only the byte being delivered is held. With deep buffering a second byte can wait behind it, so the host can write again before the peripheral answers. A status output tells the host whether a write would be accepted. A write made while the queue is full is discarded, and a one-cycle flag reports the discard. The acknowledge line is asynchronous to the port clock. It passes through a synchronizer, and only its rising edge has any effect.

Top module: `hsk_out_port`

## Requirements
- R1: While rstN is low, and on the first sampling after it is released, dataReady is 0, canWrite is 1 and wrDropped is 0. Reset empties the queue.
- R2: A byte written into an empty, idle port appears on pinData after the second rising clock edge that follows the write edge, with dataReady still 0 at that point. dataReady becomes 1 one edge later, so the data is stable for a full cycle before ready is asserted.
- R3: pinData does not change while dataReady stays 1.
- R4: A rising edge on ackIn, applied between clock edges, makes dataReady 0 after the third rising clock edge and removes the delivered byte. From then on canWrite reflects the freed slot.
- R5: If another byte is queued when an acknowledge is taken, dataReady stays 0 for exactly two cycles. The next byte is on pinData in the second of those cycles, and dataReady then returns to 1.
- R6: With cfgDouble = 0 the queue holds one byte. canWrite is 0 whenever that byte is still unacknowledged.
- R7: With cfgDouble = 1 the queue holds two bytes, which are delivered in the order they were written. canWrite is 0 when both slots are occupied.
- R8: A write with wrEn = 1 while canWrite = 0 leaves the queue unchanged. It makes wrDropped equal 1 for exactly the one cycle after that edge.
- R9: Only a rising edge of ackIn acts, and only while dataReady is 1. Holding ackIn high does not remove further bytes, and an ackIn edge while dataReady is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDouble | input | 1 | 1 selects two-byte queue, 0 selects one-byte queue |
| wrEn | input | 1 | Host write strobe, one byte per cycle |
| wrData | input | 8 | Host write byte |
| canWrite | output | 1 | A write in this cycle would be accepted |
| wrDropped | output | 1 | Pulses for one cycle after a discarded write |
| pinData | output | 8 | Byte presented to the peripheral |
| dataReady | output | 1 | Byte on pinData is valid for the peripheral |
| ackIn | input | 1 | Peripheral acknowledge, asynchronous, rising edge active |

## Verification
The bench targets four corner cases.

The first is an acknowledge held high across a second delivery, and an acknowledge pulse while nothing is presented. A design that acts on the level, or acts outside the ready phase, would silently discard a byte.

The second is a write on the cycle the queue fills, in each depth setting. A wrong full test either overwrites a queued byte or refuses a legal second byte in deep mode.

The third is the exact cycle counts of synchronizer latency, the setup cycle before ready and the two-cycle gap between bytes. A design that gets these wrong changes data under an asserted ready line.

The fourth is random host and peripheral traffic, in which the delivered order is compared with a bench-side queue and the status flag with a bench occupancy count.

// File: rtl/hsk_out_pkg.sv
package hsk_out_pkg;

  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic push;   // store wrData into the queue tail
    logic pop;    // retire the byte at the queue head
    logic load;   // copy the queue head onto the pins
  } hskStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_READY = 2'd2
  } hskState_e;

endpackage

// File: rtl/hsk_out_ctrl.sv
module hsk_out_ctrl
  import hsk_out_pkg::*;
#(
  parameter int MAX_DEPTH   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgDouble,
  input  logic             wrEn,
  input  logic             ackIn,
  input  logic [CNT_W-1:0] occupancy,
  output hskStrobes_t      strobes,
  output logic             dataReady,
  output logic             canWrite,
  output logic             wrDropped
);

  hskState_e stateQ, stateNext;
  logic [SYNC_STAGES-1:0] ackSyncQ;
  logic ackPrevQ;
  logic ackRise;
  logic [CNT_W-1:0] capLimit;

  // Acknowledge synchronizer; the number of stages is a parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ackSyncQ <= '0;
        else       ackSyncQ <= ackIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ackSyncQ <= '0;
        else       ackSyncQ <= {ackSyncQ[SYNC_STAGES-2:0], ackIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackPrevQ <= 1'b0;
    else       ackPrevQ <= ackSyncQ[SYNC_STAGES-1];
  end

  assign ackRise  = ackSyncQ[SYNC_STAGES-1] & ~ackPrevQ;
  assign capLimit = cfgDouble ? CNT_W'(MAX_DEPTH) : CNT_W'(1);
  assign canWrite = occupancy < capLimit;

  always_comb begin
    strobes.push = wrEn & canWrite;
    strobes.pop  = (stateQ == ST_READY) & ackRise;
    strobes.load = (stateQ == ST_IDLE) & (occupancy != '0);
  end

  always_comb begin
    stateNext = stateQ;
    case (stateQ)
      ST_IDLE:  if (occupancy != '0) stateNext = ST_SETUP;
      ST_SETUP: stateNext = ST_READY;
      ST_READY: if (ackRise) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      wrDropped <= 1'b0;
    end else begin
      stateQ    <= stateNext;
      wrDropped <= wrEn & ~canWrite;
    end
  end

  assign dataReady = (stateQ == ST_READY);

  // A refused write raises the drop flag on the next cycle
  assert_drop_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !canWrite) |=> wrDropped);

  // A taken acknowledge withdraws ready on the next cycle
  assert_ready_falls_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && ackRise) |=> !dataReady);

  // In one-byte mode a held byte blocks further writes
  assert_single_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgDouble && occupancy != '0) |-> !canWrite);

  // Ready is never raised without a queued byte
  assert_ready_has_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> (occupancy != '0));

endmodule

// File: rtl/hsk_out_dpath.sv
module hsk_out_dpath
  import hsk_out_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 2,
  parameter int CNT_W     = $clog2(MAX_DEPTH + 1),
  parameter int PTR_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hskStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  occupancy,
  output logic [DATA_W-1:0] pinData
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(MAX_DEPTH - 1);

  logic [DATA_W-1:0] slotQ [MAX_DEPTH];
  logic [PTR_W-1:0]  wrPtrQ, rdPtrQ;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  generate
    for (genvar e = 0; e < MAX_DEPTH; e++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strobes.push && wrPtrQ == PTR_W'(e)) slotQ[e] <= wrData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtrQ    <= '0;
      rdPtrQ    <= '0;
      occupancy <= '0;
      pinData   <= '0;
    end else begin
      if (strobes.push) wrPtrQ <= bumpPtr(wrPtrQ);
      if (strobes.pop)  rdPtrQ <= bumpPtr(rdPtrQ);
      case ({strobes.push, strobes.pop})
        2'b10:   occupancy <= occupancy + CNT_W'(1);
        2'b01:   occupancy <= occupancy - CNT_W'(1);
        default: occupancy <= occupancy;
      endcase
      if (strobes.load) pinData <= slotQ[rdPtrQ];
    end
  end

  // The control unit must never push into a full queue
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |-> (occupancy < CNT_W'(MAX_DEPTH)) || strobes.pop);

  // Retiring a byte requires one to be held
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> (occupancy != '0));

endmodule

// File: rtl/hsk_out_port.sv
module hsk_out_port
  import hsk_out_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MAX_DEPTH   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDouble,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              canWrite,
  output logic              wrDropped,
  output logic [DATA_W-1:0] pinData,
  output logic              dataReady,
  input  logic              ackIn
);

  localparam int CNT_W = $clog2(MAX_DEPTH + 1);

  hskStrobes_t      strobes;
  logic [CNT_W-1:0] occupancy;

  hsk_out_ctrl #(
    .MAX_DEPTH  (MAX_DEPTH),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgDouble(cfgDouble),
    .wrEn     (wrEn),
    .ackIn    (ackIn),
    .occupancy(occupancy),
    .strobes  (strobes),
    .dataReady(dataReady),
    .canWrite (canWrite),
    .wrDropped(wrDropped)
  );

  hsk_out_dpath #(
    .DATA_W   (DATA_W),
    .MAX_DEPTH(MAX_DEPTH),
    .CNT_W    (CNT_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .occupancy(occupancy),
    .pinData  (pinData)
  );

  // Pins hold still for as long as ready stays up
  assert_pins_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && $past(dataReady)) |-> (pinData == $past(pinData)));

  // Reset holds the port quiet with room for a write
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |-> (!dataReady && canWrite && !wrDropped));

endmodule

// File: tb/hsk_out_port_tb_top.sv
module hsk_out_port_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgDouble;
  logic       wrEn;
  logic [7:0] wrData;
  logic       canWrite;
  logic       wrDropped;
  logic [7:0] pinData;
  logic       dataReady;
  logic       ackIn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hsk_out_port dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgDouble(cfgDouble),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .canWrite (canWrite),
    .wrDropped(wrDropped),
    .pinData  (pinData),
    .dataReady(dataReady),
    .ackIn    (ackIn)
  );

  function automatic int capOf(input bit dbl);
    return dbl ? 2 : 1;
  endfunction

  function automatic bit expCanWrite(input int held, input bit dbl);
    return held < capOf(dbl);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    byte unsigned expQ[$];
    int  model;
    bit  prevReady, drove, drAcc;
    int  pState, pCnt;

    void'($urandom(32'd4242));
    rstN = 1'b0; cfgDouble = 1'b0; wrEn = 1'b0; wrData = '0; ackIn = 1'b0;
    step(3);
    check("R1 dataReady in reset", dataReady, 0);
    check("R1 canWrite in reset", canWrite, 1);
    check("R1 wrDropped in reset", wrDropped, 0);
    rstN = 1'b1;
    step(1);
    check("R1 dataReady after reset", dataReady, 0);
    check("R1 canWrite after reset", canWrite, 1);

    // Single mode: first byte, timing of data and ready
    wrEn = 1'b1; wrData = 8'hA5;
    step(1);
    wrEn = 1'b0;
    check("R6 canWrite with one held", canWrite, 0);
    check("R2 ready low at write+1", dataReady, 0);
    step(1);
    check("R2 pinData before ready", pinData, 8'hA5);
    check("R2 ready still low", dataReady, 0);
    step(1);
    check("R2 ready raised", dataReady, 1);

    // Dropped write in single mode
    wrEn = 1'b1; wrData = 8'h3C;
    step(1);
    wrEn = 1'b0;
    check("R8 drop flag set", wrDropped, 1);
    step(1);
    check("R8 drop flag one cycle", wrDropped, 0);
    check("R8 pins keep old byte", pinData, 8'hA5);
    check("R3 ready held", dataReady, 1);

    // Acknowledge latency
    ackIn = 1'b1;
    step(2);
    check("R4 ready before third edge", dataReady, 1);
    step(1);
    check("R4 ready drops on third edge", dataReady, 0);
    check("R4 slot freed", canWrite, 1);

    // Held acknowledge must not retire the next byte
    wrEn = 1'b1; wrData = 8'h11;
    step(1);
    wrEn = 1'b0;
    step(2);
    check("R9 next byte ready", dataReady, 1);
    check("R9 next byte value", pinData, 8'h11);
    step(5);
    check("R9 held ack ignored", dataReady, 1);
    ackIn = 1'b0;
    step(4);
    ackIn = 1'b1;
    step(3);
    check("R9 fresh edge retires", dataReady, 0);
    ackIn = 1'b0;

    // Acknowledge pulse while idle must be ignored
    step(4);
    ackIn = 1'b1;
    step(4);
    ackIn = 1'b0;
    step(3);
    wrEn = 1'b1; wrData = 8'h22;
    step(1);
    wrEn = 1'b0;
    step(2);
    check("R9 byte after idle ack", pinData, 8'h22);
    step(6);
    check("R9 idle ack not remembered", dataReady, 1);
    ackIn = 1'b1;
    step(3);
    ackIn = 1'b0;
    step(3);

    // Double mode: fill, overflow, order, gap
    cfgDouble = 1'b1;
    wrEn = 1'b1; wrData = 8'h01;
    step(1);
    check("R7 room for second", canWrite, 1);
    wrData = 8'h02;
    step(1);
    check("R7 full after two", canWrite, 0);
    wrData = 8'h03;
    step(1);
    wrEn = 1'b0;
    check("R8 third write dropped", wrDropped, 1);
    check("R7 first byte presented", pinData, 8'h01);
    check("R7 ready with first", dataReady, 1);
    ackIn = 1'b1;
    step(3);
    check("R4 ready drops double", dataReady, 0);
    check("R4 canWrite after pop", canWrite, 1);
    step(1);
    check("R5 gap second cycle", dataReady, 0);
    check("R5 next byte on pins", pinData, 8'h02);
    step(1);
    check("R5 ready returns", dataReady, 1);
    check("R7 second byte order", pinData, 8'h02);
    ackIn = 1'b0;
    step(3);
    ackIn = 1'b1;
    step(3);
    ackIn = 1'b0;
    check("R8 dropped byte absent", dataReady, 0);
    step(3);
    check("R8 queue empty", dataReady, 0);
    check("R7 empty canWrite", canWrite, 1);

    // Random traffic in both depth settings
    for (int ph = 0; ph < 2; ph++) begin
      cfgDouble = ph[0];
      model = 0; prevReady = 1'b0; drove = 1'b0; drAcc = 1'b0;
      pState = 0; pCnt = 0;
      expQ.delete();
      for (int cyc = 0; cyc < 1600; cyc++) begin
        step(1);
        if (prevReady && !dataReady) model--;
        if (drove) check("R8 random drop flag", wrDropped, !drAcc);
        check("R7 random canWrite", canWrite, expCanWrite(model, cfgDouble));
        drove = 1'b0;
        wrEn  = 1'b0;
        if (cyc < 1400 && ($urandom % 3) == 0) begin
          wrEn   = 1'b1;
          wrData = 8'($urandom);
          drove  = 1'b1;
          drAcc  = expCanWrite(model, cfgDouble);
          if (drAcc) begin
            expQ.push_back(wrData);
            model++;
          end
        end
        case (pState)
          0: if (dataReady) begin
               pCnt = int'($urandom % 4);
               pState = 1;
             end
          1: begin
               check("R3 ready held until ack", dataReady, 1);
               if (expQ.size() == 0) begin
                 check("R7 unexpected byte", 1, 0);
               end else begin
                 check("R3 random pin byte", pinData, expQ[0]);
               end
               if (pCnt == 0) begin
                 if (expQ.size() != 0) void'(expQ.pop_front());
                 ackIn = 1'b1;
                 pState = 2;
               end else begin
                 pCnt--;
               end
             end
          2: if (!dataReady) begin
               ackIn = 1'b0;
               pCnt = 2 + int'($urandom % 3);
               pState = 3;
             end
          default: if (pCnt == 0) pState = 0; else pCnt--;
        endcase
        prevReady = dataReady;
      end
      wrEn = 1'b0;
      ackIn = 1'b0;
      step(6);
      check("R7 random drained", expQ.size(), 0);
      check("R7 random idle", dataReady, 0);
    end

    finishRun();
  end

endmodule